// File: doc/BRIEF.md
# Eight-Pin Port with Alternate Functions

This block is a general-purpose eight-pin I/O port of the kind found beside a small processor core. It has two halves that follow different rules. The lower four pins can only drive. They stay undriven while reset is held and drive low once reset is released. The upper four pins can each be an input or an output, under a per-pin direction bit. They come out of reset as undriven inputs and have pull-ups that software can enable.

Any pin can be handed to an external-memory or refresh function in place of plain port use. The lower four pins can carry the high address nibble. Pins 4 and 5 can carry the read and write strobes. Pin 6 can feed a wait request back to the bus sequencer. Pin 7 can carry refresh pulses. A separate configuration bit enables each of these. Software reaches the output latches, the direction bits, the pull-up bits and the configuration bits over a four-register write port with a combinational read.

The pad side is one out, output-enable and in signal per pin, plus one pull-up enable per upper pin. The address source, the strobe source, the wait consumer and the refresh source lie outside the block.

Top module: `mixport8`

## Requirements
- R1: A clock edge with `rst_n` low leaves the following state. All eight `pad_oe` bits are 0. The direction, pull-up and configuration registers read back 0. Data-register bits 3:0 read 0.
- R2: After the first clock edge with `rst_n` high, `pad_oe[3:0]` is all ones and `pad_out[3:0]` is 0.
- R3: A write to register 0 (data) loads all eight latch bits. Each plain-port output pin drives its latch bit.
- R4: Register 1 (direction) bit k set makes pin 4+k an output driving latch bit 4+k. Clearing it makes pin 4+k an undriven input.
- R5: A read of register 0 returns the latch for pins 0–3 and for upper pins in output mode. For upper pins in input mode it returns `pad_in`, seen through a two-flop synchronizer.
- R6: `pad_pullup[k]` is 1 exactly when register 2 (pull-up) bit k is set and pin 4+k is in input mode.
- R7: Register 3 (configuration) bit 0 makes `pad_out[3:0]` follow `mem_addr_hi`.
- R8: Configuration bit 1 makes pins 4 and 5 outputs that carry `mem_rd` and `mem_wr`, whatever their direction bits.
- R9: `wait_req` equals the synchronized `pad_in[6]` when configuration bit 2 is set and pin 6 is in input mode. Otherwise it is 0.
- R10: Configuration bit 3 makes pin 7 an output that carries `refresh_req`, whatever its direction bit.
- R11: Data writes made while an alternate function owns a pin still load the latch. The written value shows on the pin as soon as the configuration bit is cleared.
- R12: Registers 1, 2 and 3 hold their value in bits 3:0 and read 0 in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 configuration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| mem_addr_hi | input | 4 | High address nibble from the memory controller |
| mem_rd | input | 1 | Read strobe from the memory controller |
| mem_wr | input | 1 | Write strobe from the memory controller |
| refresh_req | input | 1 | Refresh pulse from the refresh timer |
| wait_req | output | 1 | Synchronized wait request to the bus sequencer |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pullup | output | 4 | Pull-up enables for pins 4–7 |

## Verification
The hardest case to reach is a data write that lands while an alternate function owns the pin. The latch change cannot be seen on the pad until the function is released. It also cannot be seen on readback when the pin is in input mode. The bench reaches this case in two ways. Directed sequences write data with address output or refresh active, then clear the configuration bit. Random steps mix configuration, direction and data writes, so function ownership and latch updates overlap in many orders. Every step waits past the synchronizer before comparing the pads and the readback against a bench-side model.

// File: rtl/mixport_pkg.sv
// Package: shared constants and types for the eight-pin alternate-function port.
// Assumes a fixed split of four output-only pins and four bidirectional pins.
package mixport_pkg;
    localparam int PINS     = 8;
    localparam int LO_PINS  = 4;
    localparam int HI_PINS  = PINS - LO_PINS;
    localparam int SYNC_LEN = 2;

    // Positions of the alternate functions inside the upper nibble
    localparam int HI_RD   = 0;
    localparam int HI_WR   = 1;
    localparam int HI_WAIT = 2;
    localparam int HI_RFSH = 3;

    typedef enum logic [1:0] {
        RA_DATA = 2'd0,
        RA_DIR  = 2'd1,
        RA_PULL = 2'd2,
        RA_CFG  = 2'd3
    } reg_addr_e;

    // Configuration register, bit 3 down to bit 0
    typedef struct packed {
        logic refresh_en;
        logic wait_en;
        logic strobe_en;
        logic addr_ext;
    } alt_cfg_t;
endpackage

// File: rtl/port_regs.sv
// Module: port_regs
// Holds the output latches, the upper-pin direction bits, the pull-up bits
// and the alternate-function configuration. Assumes one write per cycle.
// The upper latch bits have no reset and start undefined.
module port_regs
    import mixport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [PINS-1:0]    wdata,
    output logic [PINS-1:0]    latch_q,
    output logic [HI_PINS-1:0] dir_q,
    output logic [HI_PINS-1:0] pull_q,
    output alt_cfg_t           cfg_q
);
    logic wr_data, wr_dir, wr_pull, wr_cfg;

    // Decode the write target
    always_comb begin
        wr_data = we && (addr == RA_DATA);
        wr_dir  = we && (addr == RA_DIR);
        wr_pull = we && (addr == RA_PULL);
        wr_cfg  = we && (addr == RA_CFG);
    end

    // Lower latch bits: cleared by reset, loaded on data writes
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q[LO_PINS-1:0] <= '0;
        else if (wr_data) latch_q[LO_PINS-1:0] <= wdata[LO_PINS-1:0];
    end

    // Upper latch bits: no reset, loaded on data writes
    always_ff @(posedge clk) begin
        if (rst_n && wr_data) latch_q[PINS-1:LO_PINS] <= wdata[PINS-1:LO_PINS];
    end

    // Control registers: cleared by reset, loaded on their own writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            pull_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wdata[HI_PINS-1:0];
            if (wr_pull) pull_q <= wdata[HI_PINS-1:0];
            if (wr_cfg)  cfg_q  <= alt_cfg_t'(wdata[3:0]);
        end
    end

    // Direction and configuration change only on their own writes
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == RA_DIR) |=> $stable(dir_q));
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == RA_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/port_sync.sv
// Module: port_sync
// A chain of STAGES flops per bit that brings pad inputs into the clock domain.
// Assumes STAGES >= 2. The flops have no reset, so their contents are
// undefined for the first STAGES cycles.
module port_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous pads
    always_ff @(posedge clk) stg[0] <= din;

    // Later stages shift the sample along
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stg[s] <= stg[s-1];
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/port_pinmux.sv
// Module: port_pinmux
// Chooses, for each pin, between plain-port use and its alternate function.
// Produces pad out, output enable, pull-ups and the wait request.
// Assumes lo_drive is 0 during reset and 1 afterwards.
module port_pinmux
    import mixport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lo_drive,
    input  logic [PINS-1:0]    latch_q,
    input  logic [HI_PINS-1:0] dir_q,
    input  logic [HI_PINS-1:0] pull_q,
    input  alt_cfg_t           cfg_q,
    input  logic [HI_PINS-1:0] sync_hi,
    input  logic [LO_PINS-1:0] mem_addr_hi,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic               refresh_req,
    output logic [PINS-1:0]    pad_out,
    output logic [PINS-1:0]    pad_oe,
    output logic [HI_PINS-1:0] pad_pullup,
    output logic               wait_req
);
    logic [HI_PINS-1:0] hi_out, hi_oe;

    // Lower nibble: output only, gated by the post-reset drive flag
    always_comb begin
        pad_oe[LO_PINS-1:0]  = {LO_PINS{lo_drive}};
        pad_out[LO_PINS-1:0] = cfg_q.addr_ext ? mem_addr_hi : latch_q[LO_PINS-1:0];
    end

    // Upper nibble: port defaults, overridden by strobe and refresh functions
    always_comb begin
        hi_out = latch_q[PINS-1:LO_PINS];
        hi_oe  = dir_q;
        if (cfg_q.strobe_en) begin
            hi_out[HI_RD] = mem_rd;
            hi_out[HI_WR] = mem_wr;
            hi_oe[HI_RD]  = 1'b1;
            hi_oe[HI_WR]  = 1'b1;
        end
        if (cfg_q.refresh_en) begin
            hi_out[HI_RFSH] = refresh_req;
            hi_oe[HI_RFSH]  = 1'b1;
        end
        pad_out[PINS-1:LO_PINS] = hi_out;
        pad_oe[PINS-1:LO_PINS]  = hi_oe;
    end

    // Pull-ups only on enabled pins that are in input mode
    always_comb pad_pullup = pull_q & ~dir_q;

    // Wait request needs the function enabled and the pin in input mode
    always_comb wait_req = cfg_q.wait_en && !dir_q[HI_WAIT] && sync_hi[HI_WAIT];

    p_pullup_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pullup & dir_q) == '0);
    p_strobe_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.strobe_en |-> (pad_oe[LO_PINS+HI_RD] && pad_oe[LO_PINS+HI_WR]
                             && pad_out[LO_PINS+HI_RD] == mem_rd
                             && pad_out[LO_PINS+HI_WR] == mem_wr));
    p_wait_undriven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> !pad_oe[LO_PINS+HI_WAIT]);
    p_refresh_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.refresh_en |-> (pad_oe[LO_PINS+HI_RFSH]
                              && pad_out[LO_PINS+HI_RFSH] == refresh_req));
endmodule

// File: rtl/mixport8.sv
// Module: mixport8
// Top of the eight-pin port. Joins the register file, the input synchronizer
// and the pin mux, holds the lower-nibble drive flag and forms the read data.
// Assumes the register bus and the pads share clk, and pad_in may be asynchronous.
module mixport8
    import mixport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [PINS-1:0]    reg_wdata,
    output logic [PINS-1:0]    reg_rdata,
    input  logic [LO_PINS-1:0] mem_addr_hi,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic               refresh_req,
    output logic               wait_req,
    input  logic [PINS-1:0]    pad_in,
    output logic [PINS-1:0]    pad_out,
    output logic [PINS-1:0]    pad_oe,
    output logic [HI_PINS-1:0] pad_pullup
);
    logic [PINS-1:0]    latch_q;
    logic [HI_PINS-1:0] dir_q, pull_q, sync_hi;
    alt_cfg_t           cfg_q;
    logic               lo_drive_q;
    logic [HI_PINS-1:0] hi_view;

    port_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q),
        .cfg_q   (cfg_q)
    );

    port_sync #(.W(HI_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .din  (pad_in[PINS-1:LO_PINS]),
        .dout (sync_hi)
    );

    // Lower pins stay undriven during reset and drive after release
    always_ff @(posedge clk) begin
        if (!rst_n) lo_drive_q <= 1'b0;
        else        lo_drive_q <= 1'b1;
    end

    port_pinmux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_drive    (lo_drive_q),
        .latch_q     (latch_q),
        .dir_q       (dir_q),
        .pull_q      (pull_q),
        .cfg_q       (cfg_q),
        .sync_hi     (sync_hi),
        .mem_addr_hi (mem_addr_hi),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .refresh_req (refresh_req),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pullup  (pad_pullup),
        .wait_req    (wait_req)
    );

    // Upper read view: latch for outputs, synchronized pad for inputs
    always_comb begin
        for (int k = 0; k < HI_PINS; k++)
            hi_view[k] = dir_q[k] ? latch_q[LO_PINS+k] : sync_hi[k];
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_DATA: reg_rdata = {hi_view, latch_q[LO_PINS-1:0]};
            RA_DIR:  reg_rdata = {{LO_PINS{1'b0}}, dir_q};
            RA_PULL: reg_rdata = {{LO_PINS{1'b0}}, pull_q};
            default: reg_rdata = {{LO_PINS{1'b0}}, cfg_q};
        endcase
    end

    p_lo_hiz_reset_r1: assert property (@(posedge clk)
        !rst_n |=> pad_oe == '0);
    p_lo_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pad_oe[LO_PINS-1:0] == '1);
endmodule

// File: tb/tb_mixport8.sv
module tb_mixport8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [3:0] mem_addr_hi = 4'd0;
    logic       mem_rd = 1'b1, mem_wr = 1'b1, refresh_req = 1'b0;
    logic       wait_req;
    logic [7:0] pad_in = 8'd0;
    logic [7:0] pad_out, pad_oe;
    logic [3:0] pad_pullup;

    int nchk = 0, nerr = 0;
    logic [7:0] m_lat = 8'd0;
    logic [3:0] m_dir = 4'd0, m_pu = 4'd0, m_cfg = 4'd0;

    always #2 clk = ~clk;

    mixport8 dut (.*);

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            2'd0: m_lat = d;
            2'd1: m_dir = d[3:0];
            2'd2: m_pu  = d[3:0];
            default: m_cfg = d[3:0];
        endcase
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [7:0] exp_oe();
        logic [3:0] h = m_dir;
        if (m_cfg[1]) h[1:0] = 2'b11;
        if (m_cfg[3]) h[3] = 1'b1;
        return {h, 4'hF};
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] o = m_lat;
        if (m_cfg[0]) o[3:0] = mem_addr_hi;
        if (m_cfg[1]) begin o[4] = mem_rd; o[5] = mem_wr; end
        if (m_cfg[3]) o[7] = refresh_req;
        return o;
    endfunction

    function automatic logic [7:0] exp_data();
        logic [7:0] v = m_lat;
        for (int k = 0; k < 4; k++) if (!m_dir[k]) v[4+k] = pad_in[4+k];
        return v;
    endfunction

    // Wait past the synchronizer, then compare every output with the model
    task automatic check_all(string tag);
        logic [7:0] v;
        logic [7:0] oe;
        repeat (3) @(negedge clk);
        oe = exp_oe();
        chk({tag, " oe R4"}, pad_oe, oe);
        chk({tag, " out R3"}, pad_out & oe, exp_out() & oe);
        chk({tag, " pullup R6"}, pad_pullup, m_pu & ~m_dir);
        chk({tag, " wait R9"}, wait_req, m_cfg[2] & ~m_dir[2] & pad_in[6]);
        rd(2'd0, v);
        chk({tag, " data R5"}, v, exp_data());
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        // R1: state during reset
        repeat (4) @(negedge clk);
        chk("R1 oe in reset", pad_oe, 8'h00);
        rd(2'd1, v); chk("R1 dir reset", v, 8'h00);
        rd(2'd2, v); chk("R1 pull reset", v, 8'h00);
        rd(2'd3, v); chk("R1 cfg reset", v, 8'h00);
        rd(2'd0, v); chk("R1 low latch reset", v[3:0], 4'h0);
        // R2: release, low pins drive 0 after one edge
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 low oe", pad_oe[3:0], 4'hF);
        chk("R2 low out", pad_out[3:0], 4'h0);
        chk("R4 high inputs", pad_oe[7:4], 4'h0);
        // R3, R5: data write with upper pins in input mode
        wr(2'd0, 8'hA5);
        pad_in = 8'h3C;
        check_all("R3 data");
        chk("R5 input view", reg_rdata, 8'h35);
        // R4: upper pins to output mode
        wr(2'd1, 8'h0F);
        check_all("R4 dir out");
        chk("R4 high out", pad_out[7:4], 4'hA);
        // R6: pull-ups only on input pins
        wr(2'd2, 8'h0F);
        wr(2'd1, 8'h05);
        check_all("R6 pull");
        chk("R6 pullup", pad_pullup, 4'hA);
        // R7 and R11: address function, latch written underneath
        mem_addr_hi = 4'h9;
        wr(2'd3, 8'h01);
        check_all("R7 addr");
        chk("R7 addr pins", pad_out[3:0], 4'h9);
        wr(2'd0, 8'h53);
        chk("R11 addr kept", pad_out[3:0], 4'h9);
        wr(2'd3, 8'h00);
        chk("R11 latch shows", pad_out[3:0], 4'h3);
        // R8: strobes override input mode
        wr(2'd1, 8'h00);
        mem_rd = 1'b0; mem_wr = 1'b1;
        wr(2'd3, 8'h02);
        check_all("R8 strobe");
        chk("R8 strobe pins", {pad_oe[5:4], pad_out[5:4]}, 4'b1110);
        // R9: wait follows pin 6 only in input mode
        wr(2'd3, 8'h04);
        pad_in[6] = 1'b1;
        check_all("R9 wait on");
        chk("R9 wait high", wait_req, 1'b1);
        wr(2'd1, 8'h04);
        check_all("R9 wait gated");
        chk("R9 wait blocked", wait_req, 1'b0);
        // R10 and R11: refresh function, latch shows after release
        wr(2'd1, 8'h08);
        refresh_req = 1'b1;
        wr(2'd3, 8'h08);
        wr(2'd0, 8'h00);
        check_all("R10 refresh");
        chk("R10 refresh pin", pad_out[7], 1'b1);
        wr(2'd3, 8'h00);
        chk("R11 refresh released", pad_out[7], 1'b0);
        // R12: upper bits of control registers read 0
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R12 dir readback", v, 8'h0F);
        wr(2'd2, 8'hF6); rd(2'd2, v); chk("R12 pull readback", v, 8'h06);
        wr(2'd3, 8'hFB); rd(2'd3, v); chk("R12 cfg readback", v, 8'h0B);
        // Random mix of writes and pad activity
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a = 2'($urandom);
            wr(a, 8'($urandom));
            pad_in      = 8'($urandom);
            mem_addr_hi = 4'($urandom);
            mem_rd      = 1'($urandom);
            mem_wr      = 1'($urandom);
            refresh_req = 1'($urandom);
            check_all("rand R3 R7 R8 R10 R11");
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule